// File: doc/BRIEF.md
# Single-Clock FIFO with Synchronous and Asynchronous Clear

This block is a first-in first-out buffer that runs on one clock. A producer pushes words with a write request and a consumer pulls them with a read request. Five status outputs follow the stored word count: the count itself, empty, full, a nearly-full flag set by one threshold and a nearly-empty flag set by another. A request that cannot be served is dropped: a write when the buffer is full, or a read when it is empty.

Two parameters pick the read data style. In normal style a word reaches the output after the clock edge that accepts its read. In show-ahead style the oldest stored word is already at the output, and a read only moves on to the next word. Separately, the output can come straight from storage or from an output register.

The block has two clears. The synchronous clear acts at a clock edge. The asynchronous clear zeroes the pointers, the count and the flags at once. Storage contents survive both clears. How the data output behaves after a clear depends on which clear was used and on the output style. The first word presented after a clear is stale and is not real show-ahead data.

Top module: `dualclr_fifo`

## Requirements
- R1: Words leave in the order they were accepted. `fill_level` rises by one per accepted write and falls by one per accepted read. `DEPTH` is a power of two and gives the capacity.
- R2: `is_empty` is high exactly when `fill_level` is 0. `is_full` is high exactly when it equals `DEPTH`. `nearly_full` is high when `fill_level >= AFULL_AT`. `nearly_empty` is high when `fill_level < AEMPTY_BELOW`.
- R3: If `clear_sync` is high at a rising edge, then after that edge the count is 0, both pointers point at location 0, `is_empty` and `nearly_empty` are high, and `is_full` and `nearly_full` are low. Read and write requests in that same cycle are discarded.
- R4: While `clear_async` is high, the count, pointers and flags take their cleared values with no clock edge needed. Requests presented while it is high are discarded.
- R5: A write while full and a read while empty each leave the pointers and `fill_level` unchanged.
- R6: An accepted read and an accepted write in the same cycle leave `fill_level` unchanged.
- R7: Normal style: after the edge that accepts a read, `rd_data` shows the word that was read. With registered output it holds that word until the next accepted read.
- R8: Show-ahead style: `rd_data` shows the oldest stored word. After an edge with an accepted read it shows the next word. After a write into an empty buffer it shows the written word.
- R9: Normal style, unregistered output: after a synchronous clear edge, `rd_data` shows the word held at location 0, which the clear does not erase. With registered output, `rd_data` keeps its value.
- R10: Show-ahead style, unregistered output: `rd_data` keeps its value for one cycle after a synchronous clear edge, then shows the location-0 word from the following edge. With registered output, it keeps its value.
- R11: Asserting `clear_async` never changes `rd_data` by itself. In show-ahead style with unregistered output, `rd_data` shows the location-0 word from the first rising edge after the clear is applied. The other styles keep their value until a later accepted read, or, for registered show-ahead, a write into an empty buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clear_async | input | 1 | Asynchronous clear, active high |
| clear_sync | input | 1 | Synchronous clear, active high |
| wr_req | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| rd_req | input | 1 | Read request |
| rd_data | output | DATA_W | Output word |
| is_full | output | 1 | Count equals DEPTH |
| nearly_full | output | 1 | Count at or above AFULL_AT |
| is_empty | output | 1 | Count is zero |
| nearly_empty | output | 1 | Count below AEMPTY_BELOW |
| fill_level | output | $clog2(DEPTH)+1 | Stored word count |

## Verification
All four output styles run side by side on identical stimulus. This separates the cases where the clears must affect each style differently from the cases where all styles must agree.

Directed phases each target one behaviour:
- Filling past capacity and draining past empty exposes any request that is served when it should be dropped.
- Paired reads and writes check that the count stays put.
- A synchronous clear pulse while data is stored, with both requests raised, tells the immediate location-0 view apart from the one-cycle hold and from the registered hold.
- An asynchronous pulse placed between edges shows whether the flags change without a clock and whether the data output wrongly moves.

Random traffic then runs with fill-biased, drain-biased and balanced request mixes, together with occasional clears of both kinds. This covers wrap-around, threshold crossings and writes into an empty buffer.

// File: rtl/dualclr_fifo_pkg.sv
package dualclr_fifo_pkg;

    // Read data style: bit 1 selects show-ahead, bit 0 selects a registered output.
    typedef enum logic [1:0] {
        OUT_NORM_COMB  = 2'd0,
        OUT_NORM_REG   = 2'd1,
        OUT_AHEAD_COMB = 2'd2,
        OUT_AHEAD_REG  = 2'd3
    } out_style_e;

    function automatic out_style_e style_of(input bit ahead, input bit regd);
        return out_style_e'({ahead, regd});
    endfunction

endpackage

// File: rtl/dualclr_fifo_store.sv
module dualclr_fifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    // Storage is never cleared; only the pointers are.
    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/dualclr_fifo_ctrl.sv
module dualclr_fifo_ctrl #(
    parameter int DEPTH        = 16,
    parameter int AFULL_AT     = 12,
    parameter int AEMPTY_BELOW = 3,
    parameter int AW           = $clog2(DEPTH),
    parameter int CW           = AW + 1
) (
    input  logic          clk,
    input  logic          clear_async,
    input  logic          clear_sync,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] rd_ptr_nxt,
    output logic [CW-1:0] level,
    output logic          is_full,
    output logic          nearly_full,
    output logic          is_empty,
    output logic          nearly_empty
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] AF_CNT   = CW'(AFULL_AT);
    localparam logic [CW-1:0] AE_CNT   = CW'(AEMPTY_BELOW);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        wr_ok = wr_req && (st_q.cnt != FULL_CNT) && !clear_sync && !clear_async;
        rd_ok = rd_req && (st_q.cnt != '0) && !clear_sync && !clear_async;
        st_d  = st_q;
        if (clear_sync) begin
            st_d = '0;
        end else begin
            if (wr_ok) begin
                st_d.wp = st_q.wp + AW'(1);
            end
            if (rd_ok) begin
                st_d.rp = st_q.rp + AW'(1);
            end
            case ({wr_ok, rd_ok})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or posedge clear_async) begin
        if (clear_async) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr       = st_q.wp;
    assign rd_ptr       = st_q.rp;
    assign rd_ptr_nxt   = st_d.rp;
    assign level        = st_q.cnt;
    assign is_full      = (st_q.cnt == FULL_CNT);
    assign nearly_full  = (st_q.cnt >= AF_CNT);
    assign is_empty     = (st_q.cnt == '0);
    assign nearly_empty = (st_q.cnt < AE_CNT);

    // R3: synchronous clear zeroes pointers and count at the edge
    a_r3_sync_clear: assert property (@(posedge clk) disable iff (clear_async)
        clear_sync |=> (level == '0 && wr_ptr == '0 && rd_ptr == '0));

    // R5: write on a full buffer is dropped
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (clear_async)
        (wr_req && !rd_req && is_full && !clear_sync) |=> (is_full && $stable(wr_ptr)));

    // R5: read on an empty buffer is dropped
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (clear_async)
        (rd_req && !wr_req && is_empty && !clear_sync) |=> (is_empty && $stable(rd_ptr)));

    // R6: paired transfer keeps the count
    a_r6_balanced: assert property (@(posedge clk) disable iff (clear_async)
        (wr_ok && rd_ok) |=> $stable(level));

endmodule

// File: rtl/dualclr_fifo_out.sv
module dualclr_fifo_out
    import dualclr_fifo_pkg::*;
#(
    parameter int         DATA_W = 8,
    parameter int         AW     = 4,
    parameter out_style_e STYLE  = OUT_NORM_COMB
) (
    input  logic              clk,
    input  logic              clear_async,
    input  logic              clear_sync,
    input  logic              rd_ok,
    input  logic              wr_ok,
    input  logic              is_empty,
    input  logic [AW-1:0]     wr_ptr,
    input  logic [AW-1:0]     rd_ptr,
    input  logic [AW-1:0]     rd_ptr_nxt,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [AW-1:0]     mem_raddr,
    output logic [DATA_W-1:0] rd_data
);

    localparam bit REGD = (STYLE == OUT_NORM_REG) || (STYLE == OUT_AHEAD_REG);

    typedef struct packed {
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        mem_raddr = st_q.addr;
        case (STYLE)
            OUT_NORM_COMB: begin
                if (clear_sync) begin
                    st_d.addr = '0;
                end else if (rd_ok) begin
                    st_d.addr = rd_ptr;
                end
            end
            OUT_NORM_REG: begin
                mem_raddr = rd_ptr;
                if (rd_ok) begin
                    st_d.data = mem_rdata;
                end
            end
            OUT_AHEAD_COMB: begin
                if (!clear_sync) begin
                    st_d.addr = rd_ptr_nxt;
                end
            end
            default: begin
                mem_raddr = rd_ptr_nxt;
                if (rd_ok || (wr_ok && is_empty)) begin
                    st_d.data = (wr_ok && (wr_ptr == rd_ptr_nxt)) ? wr_data : mem_rdata;
                end
            end
        endcase
        rd_data = REGD ? st_q.data : mem_rdata;
    end

    // No reset: neither clear may disturb the presented word directly.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    generate
        if (STYLE == OUT_NORM_COMB) begin : g_chk_nc
            // R9: after a synchronous clear the output looks at location 0
            a_r9_sync_first: assert property (@(posedge clk) disable iff (clear_async)
                clear_sync |=> (mem_raddr == '0));
        end else begin : g_chk_hold
            // R9 (registered) and R10: output holds across the clear edge
            a_r10_sync_hold: assert property (@(posedge clk) disable iff (clear_async)
                clear_sync |=> $stable(rd_data));
        end
        if (STYLE == OUT_AHEAD_COMB) begin : g_chk_sa
            // R8: head advances with each accepted read
            a_r8_head_step: assert property (@(posedge clk) disable iff (clear_async)
                rd_ok |=> (mem_raddr == $past(rd_ptr) + AW'(1)));
        end
    endgenerate

endmodule

// File: rtl/dualclr_fifo.sv
module dualclr_fifo
    import dualclr_fifo_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int DEPTH        = 16,
    parameter int AFULL_AT     = 12,
    parameter int AEMPTY_BELOW = 3,
    parameter bit SHOW_AHEAD   = 1'b0,
    parameter bit REG_OUT      = 1'b0
) (
    input  logic                     clk,
    input  logic                     clear_async,
    input  logic                     clear_sync,
    input  logic                     wr_req,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_req,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     is_full,
    output logic                     nearly_full,
    output logic                     is_empty,
    output logic                     nearly_empty,
    output logic [$clog2(DEPTH):0]   fill_level
);

    localparam int         AW    = $clog2(DEPTH);
    localparam int         CW    = AW + 1;
    localparam out_style_e STYLE = style_of(SHOW_AHEAD, REG_OUT);

    logic              wr_ok, rd_ok;
    logic [AW-1:0]     wr_ptr, rd_ptr, rd_ptr_nxt, mem_raddr;
    logic [DATA_W-1:0] mem_rdata;

    dualclr_fifo_ctrl #(
        .DEPTH(DEPTH), .AFULL_AT(AFULL_AT), .AEMPTY_BELOW(AEMPTY_BELOW), .AW(AW), .CW(CW)
    ) u_ctrl (
        .clk(clk), .clear_async(clear_async), .clear_sync(clear_sync),
        .wr_req(wr_req), .rd_req(rd_req), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rd_ptr_nxt(rd_ptr_nxt), .level(fill_level),
        .is_full(is_full), .nearly_full(nearly_full),
        .is_empty(is_empty), .nearly_empty(nearly_empty)
    );

    dualclr_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .we(wr_ok), .waddr(wr_ptr), .wdata(wr_data),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    dualclr_fifo_out #(.DATA_W(DATA_W), .AW(AW), .STYLE(STYLE)) u_out (
        .clk(clk), .clear_async(clear_async), .clear_sync(clear_sync),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .is_empty(is_empty),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rd_ptr_nxt(rd_ptr_nxt),
        .wr_data(wr_data), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr), .rd_data(rd_data)
    );

endmodule

// File: tb/dualclr_fifo_tb.sv
module dualclr_fifo_tb;

    localparam int DW = 8;
    localparam int D  = 16;
    localparam int AF = 12;
    localparam int AE = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          clear_async = 1'b1;
    logic          clear_sync  = 1'b0;
    logic          wr_req      = 1'b0;
    logic          rd_req      = 1'b0;
    logic [DW-1:0] wr_data     = '0;

    logic [DW-1:0] dq [4];
    logic          fl, nf, em, ne;
    logic [4:0]    lvl;
    logic          fl1, nf1, em1, ne1, fl2, nf2, em2, ne2, fl3, nf3, em3, ne3;
    logic [4:0]    lvl1, lvl2, lvl3;

    dualclr_fifo #(.DATA_W(DW), .DEPTH(D), .AFULL_AT(AF), .AEMPTY_BELOW(AE),
                   .SHOW_AHEAD(1'b0), .REG_OUT(1'b0)) u_dut (
        .clk(clk), .clear_async(clear_async), .clear_sync(clear_sync), .wr_req(wr_req),
        .wr_data(wr_data), .rd_req(rd_req), .rd_data(dq[0]), .is_full(fl),
        .nearly_full(nf), .is_empty(em), .nearly_empty(ne), .fill_level(lvl));
    dualclr_fifo #(.DATA_W(DW), .DEPTH(D), .AFULL_AT(AF), .AEMPTY_BELOW(AE),
                   .SHOW_AHEAD(1'b0), .REG_OUT(1'b1)) u_dut_nr (
        .clk(clk), .clear_async(clear_async), .clear_sync(clear_sync), .wr_req(wr_req),
        .wr_data(wr_data), .rd_req(rd_req), .rd_data(dq[1]), .is_full(fl1),
        .nearly_full(nf1), .is_empty(em1), .nearly_empty(ne1), .fill_level(lvl1));
    dualclr_fifo #(.DATA_W(DW), .DEPTH(D), .AFULL_AT(AF), .AEMPTY_BELOW(AE),
                   .SHOW_AHEAD(1'b1), .REG_OUT(1'b0)) u_dut_sa (
        .clk(clk), .clear_async(clear_async), .clear_sync(clear_sync), .wr_req(wr_req),
        .wr_data(wr_data), .rd_req(rd_req), .rd_data(dq[2]), .is_full(fl2),
        .nearly_full(nf2), .is_empty(em2), .nearly_empty(ne2), .fill_level(lvl2));
    dualclr_fifo #(.DATA_W(DW), .DEPTH(D), .AFULL_AT(AF), .AEMPTY_BELOW(AE),
                   .SHOW_AHEAD(1'b1), .REG_OUT(1'b1)) u_dut_sr (
        .clk(clk), .clear_async(clear_async), .clear_sync(clear_sync), .wr_req(wr_req),
        .wr_data(wr_data), .rd_req(rd_req), .rd_data(dq[3]), .is_full(fl3),
        .nearly_full(nf3), .is_empty(em3), .nearly_empty(ne3), .fill_level(lvl3));

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic [DW-1:0] m_mem [D];
    bit            m_ok  [D];
    int            m_wp = 0, m_rp = 0, m_cnt = 0;
    int            a0 = 0, a2 = 0;
    bit            a0_ok = 0, a2_ok = 0, e1_ok = 0, e3_ok = 0;
    logic [DW-1:0] e1 = '0, e3 = '0;
    string         lvl_tag = "R1";
    string         ev = "none";

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Model update for one rising edge, using the inputs held during the cycle.
    task automatic model_edge();
        bit wok, rok;
        int nrp;
        if (clear_async) begin
            m_wp = 0; m_rp = 0; m_cnt = 0;
            a2 = 0; a2_ok = 1;
            ev = "async"; lvl_tag = "R4";
        end else if (clear_sync) begin
            m_wp = 0; m_rp = 0; m_cnt = 0;
            a0 = 0; a0_ok = 1;
            ev = "sync"; lvl_tag = "R3";
        end else begin
            wok = wr_req && (m_cnt < D);
            rok = rd_req && (m_cnt > 0);
            nrp = rok ? (m_rp + 1) % D : m_rp;
            ev = "none";
            if ((wr_req && !wok) || (rd_req && !rok)) lvl_tag = "R5";
            else if (wok && rok) lvl_tag = "R6";
            else lvl_tag = "R1";
            if (rok) begin
                a0 = m_rp; a0_ok = 1;
                e1 = m_mem[m_rp]; e1_ok = m_ok[m_rp];
            end
            if (rok || (wok && m_cnt == 0)) begin
                if (wok && m_wp == nrp) begin
                    e3 = wr_data; e3_ok = 1;
                end else begin
                    e3 = m_mem[nrp]; e3_ok = m_ok[nrp];
                end
            end
            a2 = nrp; a2_ok = 1;
            if (wok) begin
                m_mem[m_wp] = wr_data; m_ok[m_wp] = 1;
                m_wp = (m_wp + 1) % D;
            end
            m_cnt = m_cnt + (wok ? 1 : 0) - (rok ? 1 : 0);
            m_rp = nrp;
        end
    endtask

    task automatic check_data();
        string t01, t23;
        if (ev == "sync")       begin t01 = "R9";  t23 = "R10"; end
        else if (ev == "async") begin t01 = "R11"; t23 = "R11"; end
        else                    begin t01 = "R7";  t23 = "R8";  end
        if (a0_ok && m_ok[a0]) chk(t01, "normal comb rd_data", 32'(dq[0]), 32'(m_mem[a0]));
        if (e1_ok)             chk(t01, "normal reg rd_data", 32'(dq[1]), 32'(e1));
        if (a2_ok && m_ok[a2]) chk(t23, "ahead comb rd_data", 32'(dq[2]), 32'(m_mem[a2]));
        if (e3_ok)             chk(t23, "ahead reg rd_data", 32'(dq[3]), 32'(e3));
    endtask

    task automatic check_all();
        chk(lvl_tag, "fill_level", 32'(lvl), 32'(m_cnt));
        chk("R2", "is_empty", 32'(em), 32'(m_cnt == 0));
        chk("R2", "is_full", 32'(fl), 32'(m_cnt == D));
        chk("R2", "nearly_full", 32'(nf), 32'(m_cnt >= AF));
        chk("R2", "nearly_empty", 32'(ne), 32'(m_cnt < AE));
        check_data();
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    task automatic drive(bit w, bit r, logic [DW-1:0] d);
        wr_req = w; rd_req = r; wr_data = d;
    endtask

    // Asynchronous pulse placed between edges, with requests raised (R4, R11).
    task automatic pulse_async();
        logic [DW-1:0] snap [4];
        for (int i = 0; i < 4; i++) snap[i] = dq[i];
        drive(1'b1, 1'b1, 8'h5A);
        clear_async = 1'b1;
        #1;
        chk("R4", "immediate fill_level", 32'(lvl), 32'd0);
        chk("R4", "immediate is_empty", 32'(em), 32'd1);
        chk("R4", "immediate nearly_empty", 32'(ne), 32'd1);
        chk("R4", "immediate is_full", 32'(fl), 32'd0);
        chk("R4", "immediate nearly_full", 32'(nf), 32'd0);
        for (int i = 0; i < 4; i++) chk("R11", "rd_data at async clear", 32'(dq[i]), 32'(snap[i]));
        cycle();
        clear_async = 1'b0;
        drive(1'b0, 1'b0, '0);
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        for (int i = 0; i < D; i++) m_ok[i] = 0;

        // Reset state under the asynchronous clear (R4, R2)
        cycle();
        cycle();
        clear_async = 1'b0;
        cycle();

        // Fill past capacity (R1, R2, R5, R8)
        for (int i = 0; i < D + 2; i++) begin
            drive(1'b1, 1'b0, 8'(8'hA0 + i));
            cycle();
        end
        // Paired transfers on a full buffer are limited to reads; drop one first (R6)
        drive(1'b0, 1'b1, '0);
        cycle();
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, 1'b1, 8'(8'hC0 + i));
            cycle();
        end
        // Drain past empty (R1, R5, R7)
        for (int i = 0; i < D + 2; i++) begin
            drive(1'b0, 1'b1, '0);
            cycle();
        end

        // Synchronous clear with data stored and both requests raised (R3, R9, R10)
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 1'b0, 8'(8'h30 + i));
            cycle();
        end
        drive(1'b0, 1'b1, '0);
        cycle();
        drive(1'b1, 1'b1, 8'hEE);
        clear_sync = 1'b1;
        cycle();
        clear_sync = 1'b0;
        drive(1'b0, 1'b0, '0);
        cycle();
        cycle();
        // First real write after the clear becomes valid head data (R8)
        drive(1'b1, 1'b0, 8'h77);
        cycle();
        drive(1'b0, 1'b1, '0);
        cycle();

        // Asynchronous clear with data stored (R4, R11)
        for (int i = 0; i < 5; i++) begin
            drive(1'b1, 1'b0, 8'(8'h90 + i));
            cycle();
        end
        pulse_async();

        // Random traffic in three mixes with occasional clears
        for (int ph = 0; ph < 3; ph++) begin
            int pw = (ph == 0) ? 75 : (ph == 1) ? 30 : 55;
            int pr = (ph == 0) ? 30 : (ph == 1) ? 75 : 55;
            for (int n = 0; n < 1000; n++) begin
                drive(($urandom % 100) < pw, ($urandom % 100) < pr, 8'($urandom));
                clear_sync = (($urandom % 60) == 0);
                if ((n % 250) == 125) begin
                    clear_sync = 1'b0;
                    pulse_async();
                end else begin
                    cycle();
                end
            end
        end
        clear_sync = 1'b0;
        drive(1'b0, 1'b0, '0);
        cycle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule